// File: doc/BRIEF.md
# PCI DMA Window Translator

This block sits at the inbound side of a PCI host bridge and classifies every DMA address that a device presents. Four programmable target windows and one fixed 64-bit bypass window are examined in parallel. A hit in a direct window yields the system address at once. A hit in a scatter-gather window yields the physical address of the 8-byte page-table entry that a downstream walker must fetch. Addresses that match nothing raise a miss flag.

Software programs each window through a small write port. Every window has three registers: a base (carrying an enable bit and a scatter-gather bit), a size mask, and a translated base. A separate control register holds the bypass enable. The result is registered, so a request presented in one cycle is answered after the next rising edge.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset every window is disabled, the bypass is off, all outputs are zero, and any request is answered with a miss.
- R2: Window w hits when its base bit 0 (enable) is set, the request's upper 32 bits are zero (always true for a single-address cycle, whose upper bits are ignored), and address bits 31:20 outside the mask equal the base bits outside the mask; mask bits 19:0 always count as set. Writing zero to a window's base disables it.
- R3: A direct window (base bit 1 clear) returns mode 0 and the system address (address AND mask) OR translated base, 35 bits wide.
- R4: A scatter-gather window (base bit 1 set) returns mode 1 and translated base plus ((address AND mask) >> 13) * 8.
- R5: When several windows hit, the lowest-numbered one is reported on rsp_win.
- R6: A dual-address cycle whose bits 63:40 equal 0x000001 returns mode 2 and address bits 34:0 unchanged, whatever bits 39:35 hold; rsp_win is 0.
- R7: The bypass is taken only while control bit 0 (cfg_sel 3) is set and only for dual-address cycles; a single-address cycle never reaches it.
- R8: A translated-base write (cfg_sel 2) with any of bits 9:0 set is rejected: the stored value is kept and cfg_err is high for the following cycle only.
- R9: Results appear one cycle after req_valid; exactly one of rsp_hit and rsp_miss is set for a request, and neither is set when no request was made. On a miss rsp_win, rsp_mode and rsp_addr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window selected by the write |
| cfg_sel | input | 2 | 0 base, 1 mask, 2 translated base, 3 control |
| cfg_wdata | input | 35 | Write data |
| cfg_err | output | 1 | Rejected translated-base write, one cycle late |
| req_valid | input | 1 | Address to translate is present |
| req_dac | input | 1 | Request is a dual-address cycle |
| req_addr | input | 64 | PCI address |
| rsp_valid | output | 1 | Result of previous cycle's request |
| rsp_hit | output | 1 | A window or the bypass matched |
| rsp_miss | output | 1 | Nothing matched |
| rsp_win | output | 2 | Winning window number |
| rsp_mode | output | 2 | 0 direct, 1 scatter-gather, 2 bypass |
| rsp_addr | output | 35 | System address or page-table entry address |

## Verification
The assertions assume that the write port and the request port are not used to change a window in the same cycle that a request depends on it; the stimulus always separates writes from requests by at least one cycle. They also assume req_dac is only meaningful with req_valid, and the bench drives it low otherwise. The stimulus covers overlapping windows, a disabled window, bypass tags with varying bits 39:35, and a rejected translated base, followed by random addresses spread over the programmed ranges.

// File: rtl/pci_xlate_pkg.sv
// Shared types for the DMA window translator.
// Assumes a two-bit result mode and a two-bit register select.
package pci_xlate_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_SG     = 2'd1,
        MODE_BYPASS = 2'd2
    } xlate_mode_e;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_TBA  = 2'd2,
        SEL_CTRL = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/pci_xlate_regs.sv
// Window register file: base, mask and translated base per window plus
// a bypass enable. Rejects translated bases with low bits set and pulses
// an error flag the cycle after. Assumes SYS_W >= ADDR_W.
module pci_xlate_regs #(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 32,
    parameter int SYS_W   = 35,
    parameter int TBA_LSB = 10,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [IDX_W-1:0]                  cfg_win,
    input  logic [1:0]                        cfg_sel,
    input  logic [SYS_W-1:0]                  cfg_wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]    base_q,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]    mask_q,
    output logic [NUM_WIN-1:0][SYS_W-1:0]     tba_q,
    output logic                              byp_en_q,
    output logic                              cfg_err
);
    import pci_xlate_pkg::*;

    cfg_sel_e sel;
    logic     tba_bad;

    assign sel     = cfg_sel_e'(cfg_sel);
    assign tba_bad = cfg_we && (sel == SEL_TBA) && (|cfg_wdata[TBA_LSB-1:0]);

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            logic pick;
            assign pick = cfg_we && (cfg_win == IDX_W'(w));

            // Per-window register update
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_q[w] <= '0;
                    mask_q[w] <= '0;
                    tba_q[w]  <= '0;
                end else if (pick) begin
                    if (sel == SEL_BASE) base_q[w] <= cfg_wdata[ADDR_W-1:0];
                    if (sel == SEL_MASK) mask_q[w] <= cfg_wdata[ADDR_W-1:0];
                    if (sel == SEL_TBA && !tba_bad) tba_q[w] <= cfg_wdata;
                end
            end
        end
    endgenerate

    // Global bypass enable and rejected-write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_en_q <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            if (cfg_we && sel == SEL_CTRL) byp_en_q <= cfg_wdata[0];
            cfg_err <= tba_bad;
        end
    end

endmodule

// File: rtl/pci_xlate_win.sv
// One target window: masked compare plus direct and page-table-entry
// address generation. Combinational. Assumes mask bits below WIN_LSB
// are implicitly set and that SYS_W > ADDR_W.
module pci_xlate_win #(
    parameter int ADDR_W     = 32,
    parameter int SYS_W      = 35,
    parameter int WIN_LSB    = 20,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_ok,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [SYS_W-1:0]  tba,
    output logic              hit,
    output logic              is_sg,
    output logic [SYS_W-1:0]  xaddr
);
    logic [ADDR_W-1:0] eff_mask;
    logic [SYS_W-1:0]  offs;

    // Compare the bits outside the window and build both address forms
    always_comb begin
        eff_mask = {mask[ADDR_W-1:WIN_LSB], {WIN_LSB{1'b1}}};
        hit      = base[0] && addr_ok && ((addr & ~eff_mask) == (base & ~eff_mask));
        is_sg    = base[1];
        offs     = {{(SYS_W-ADDR_W){1'b0}}, addr & eff_mask};
        xaddr    = is_sg ? (tba + ((offs >> PAGE_SHIFT) << PTE_SHIFT))
                         : (offs | tba);
    end

endmodule

// File: rtl/pci_dma_xlate.sv
// Top of the DMA window translator: register file, parallel windows with
// lowest-index priority, fixed dual-address bypass, registered result.
// Assumes writes do not coincide with requests that depend on them.
module pci_dma_xlate #(
    parameter int NUM_WIN    = 4,
    parameter int ADDR_W     = 32,
    parameter int SYS_W      = 35,
    parameter int DAC_W      = 64,
    parameter int WIN_LSB    = 20,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3,
    parameter int TBA_LSB    = 10,
    parameter int BYP_LSB    = 40,
    parameter logic [DAC_W-BYP_LSB-1:0] BYP_TAG = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_WIN)-1:0] cfg_win,
    input  logic [1:0]                 cfg_sel,
    input  logic [SYS_W-1:0]           cfg_wdata,
    output logic                       cfg_err,
    input  logic                       req_valid,
    input  logic                       req_dac,
    input  logic [DAC_W-1:0]           req_addr,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic                       rsp_miss,
    output logic [$clog2(NUM_WIN)-1:0] rsp_win,
    output logic [1:0]                 rsp_mode,
    output logic [SYS_W-1:0]           rsp_addr
);
    import pci_xlate_pkg::*;
    localparam int IDX_W = $clog2(NUM_WIN);

    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q, mask_q;
    logic [NUM_WIN-1:0][SYS_W-1:0]  tba_q, win_addr;
    logic [NUM_WIN-1:0]             win_hit, win_sg;
    logic                           byp_en_q, addr_ok, byp_hit;
    logic                           any_hit;
    logic [IDX_W-1:0]               sel_win;
    xlate_mode_e                    sel_mode;
    logic [SYS_W-1:0]               sel_addr;

    pci_xlate_regs #(
        .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .SYS_W(SYS_W), .TBA_LSB(TBA_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .base_q(base_q),
        .mask_q(mask_q), .tba_q(tba_q), .byp_en_q(byp_en_q), .cfg_err(cfg_err)
    );

    // Single-address cycles carry no upper half; dual ones must have it zero
    assign addr_ok = !req_dac || (req_addr[DAC_W-1:ADDR_W] == '0);
    assign byp_hit = req_dac && byp_en_q && (req_addr[DAC_W-1:BYP_LSB] == BYP_TAG);

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            pci_xlate_win #(
                .ADDR_W(ADDR_W), .SYS_W(SYS_W), .WIN_LSB(WIN_LSB),
                .PAGE_SHIFT(PAGE_SHIFT), .PTE_SHIFT(PTE_SHIFT)
            ) u_win (
                .addr(req_addr[ADDR_W-1:0]), .addr_ok(addr_ok),
                .base(base_q[w]), .mask(mask_q[w]), .tba(tba_q[w]),
                .hit(win_hit[w]), .is_sg(win_sg[w]), .xaddr(win_addr[w])
            );
        end
    endgenerate

    // Pick the lowest-numbered hitting window, else the bypass
    always_comb begin
        any_hit  = 1'b0;
        sel_win  = '0;
        sel_mode = MODE_DIRECT;
        sel_addr = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_hit[w] && !any_hit) begin
                any_hit  = 1'b1;
                sel_win  = IDX_W'(w);
                sel_mode = win_sg[w] ? MODE_SG : MODE_DIRECT;
                sel_addr = win_addr[w];
            end
        end
        if (!any_hit && byp_hit) begin
            any_hit  = 1'b1;
            sel_mode = MODE_BYPASS;
            sel_addr = req_addr[SYS_W-1:0];
        end
    end

    // Register the result one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_win   <= '0;
            rsp_mode  <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && any_hit;
            rsp_miss  <= req_valid && !any_hit;
            rsp_win   <= (req_valid && any_hit) ? sel_win : '0;
            rsp_mode  <= (req_valid && any_hit) ? sel_mode : MODE_DIRECT;
            rsp_addr  <= (req_valid && any_hit) ? sel_addr : '0;
        end
    end

endmodule

// File: rtl/pci_dma_xlate_chk.sv
// Property checker for the translator, attached by bind below.
module pci_dma_xlate_chk #(
    parameter int SYS_W   = 35,
    parameter int DAC_W   = 64,
    parameter int TBA_LSB = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_sel,
    input logic [SYS_W-1:0] cfg_wdata,
    input logic             cfg_err,
    input logic             req_valid,
    input logic             req_dac,
    input logic [DAC_W-1:0] req_addr,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic [1:0]       rsp_mode,
    input logic [SYS_W-1:0] rsp_addr
);
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_hit && !rsp_miss));

    p_byp_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_mode == 2'd2) |-> (rsp_addr == $past(req_addr[SYS_W-1:0])));

    p_byp_dac_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dac) |=> !(rsp_hit && rsp_mode == 2'd2));

    p_bad_tba_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd2 && (|cfg_wdata[TBA_LSB-1:0])) |=> cfg_err);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == 2'd2) |=> !cfg_err);

endmodule

bind pci_dma_xlate pci_dma_xlate_chk #(
    .SYS_W(SYS_W), .DAC_W(DAC_W), .TBA_LSB(TBA_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .req_valid(req_valid),
    .req_dac(req_dac), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_mode(rsp_mode),
    .rsp_addr(rsp_addr)
);

// File: tb/pci_dma_xlate_tb.sv
module pci_dma_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [34:0] cfg_wdata = '0;
    logic        cfg_err;
    logic        req_valid = 1'b0;
    logic        req_dac = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [1:0]  rsp_win, rsp_mode;
    logic [34:0] rsp_addr;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    pci_dma_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_dac(req_dac), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_mode(rsp_mode), .rsp_addr(rsp_addr)
    );

    // Reference model state
    longint m_base[4], m_mask[4], m_tba[4];
    bit     m_byp;
    bit     e_valid, e_hit, e_miss, e_err;
    int     e_win, e_mode;
    longint e_addr;
    string  e_tag;

    task automatic note(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    // Behavioural translation from the written requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 4; w++) begin m_base[w] = 0; m_mask[w] = 0; m_tba[w] = 0; end
            m_byp = 0; e_valid = 0; e_hit = 0; e_miss = 0; e_err = 0;
            e_win = 0; e_mode = 0; e_addr = 0; e_tag = "R1";
        end else begin
            longint lo, span, off;
            bit found;
            found = 0; e_win = 0; e_mode = 0; e_addr = 0;
            lo = longint'(req_addr[31:0]);
            if (req_valid) begin
                for (int w = 0; w < 4; w++) begin
                    span = (m_mask[w] & 64'hFFF0_0000) | 64'hF_FFFF;
                    if (!found && m_base[w][0] && (!req_dac || req_addr[63:32] == 0)
                        && ((lo & ~span & 64'hFFFF_FFFF) == (m_base[w] & ~span & 64'hFFFF_FFFF))) begin
                        found = 1; e_win = w;
                        off = lo & span;
                        if (m_base[w][1]) begin
                            e_mode = 1; e_addr = (m_tba[w] + (off / 8192) * 8) & 64'h7_FFFF_FFFF;
                        end else begin
                            e_mode = 0; e_addr = off | m_tba[w];
                        end
                    end
                end
                if (!found && req_dac && m_byp && req_addr[63:40] == 24'h000001) begin
                    found = 1; e_mode = 2; e_addr = longint'(req_addr[34:0]);
                end
            end
            e_valid = req_valid; e_hit = req_valid && found; e_miss = req_valid && !found;
            e_tag = cur_tag;
            e_err = cfg_we && cfg_sel == 2 && cfg_wdata[9:0] != 0;
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_base[cfg_win] = longint'(cfg_wdata[31:0]);
                    2'd1: m_mask[cfg_win] = longint'(cfg_wdata[31:0]);
                    2'd2: if (!e_err) m_tba[cfg_win] = longint'(cfg_wdata);
                    default: m_byp = cfg_wdata[0];
                endcase
            end
        end
    end

    // Compare against the model every clock, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            note({rsp_valid, rsp_hit, rsp_miss, cfg_err} == {e_valid, e_hit, e_miss, e_err}, e_tag,
                 $sformatf("flags v/h/m/err act=%b%b%b%b exp=%b%b%b%b", rsp_valid, rsp_hit,
                           rsp_miss, cfg_err, e_valid, e_hit, e_miss, e_err));
            note(rsp_win == e_win[1:0] && rsp_mode == e_mode[1:0] && rsp_addr == e_addr[34:0], e_tag,
                 $sformatf("win/mode/addr act=%0d/%0d/%h exp=%0d/%0d/%h", rsp_win, rsp_mode,
                           rsp_addr, e_win, e_mode, e_addr[34:0]));
        end
    end

    task automatic wr(input int w, input int sel, input longint data, input string tag);
        cur_tag = tag;
        cfg_we = 1; cfg_win = w[1:0]; cfg_sel = sel[1:0]; cfg_wdata = data[34:0];
        @(negedge clk);
        cfg_we = 0; cfg_wdata = '0;
    endtask

    task automatic rq(input bit dac, input logic [63:0] a, input string tag);
        cur_tag = tag;
        req_valid = 1; req_dac = dac; req_addr = a;
        @(negedge clk);
        req_valid = 0; req_dac = 0; req_addr = '0;
    endtask

    // Direct expectation checks on specific cases, on top of the model
    task automatic expect_now(input string tag, input bit hit, input int win, input int mode,
                              input longint a);
        note(rsp_hit == hit && rsp_win == win[1:0] && rsp_mode == mode[1:0] && rsp_addr == a[34:0],
             tag, $sformatf("direct check act=%b/%0d/%0d/%h exp=%b/%0d/%0d/%h", rsp_hit, rsp_win,
                            rsp_mode, rsp_addr, hit, win, mode, a[34:0]));
    endtask

    task automatic rq_chk(input bit dac, input logic [63:0] a, input string tag, input bit hit,
                          input int win, input int mode, input longint ex);
        rq(dac, a, tag);
        expect_now(tag, hit, win, mode, ex);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        note({rsp_valid, rsp_hit, rsp_miss, cfg_err, rsp_addr} == '0, "R1",
             $sformatf("reset outputs act=%h exp=0", {rsp_valid, rsp_hit, rsp_miss, cfg_err, rsp_addr}));
        rst_n = 1;
        @(negedge clk);
        chk_on = 1;
        // R1: nothing programmed, every request misses
        rq_chk(0, 64'h8000_0000, "R1", 0, 0, 0, 0);
        rq_chk(1, 64'h0000_0100_0000_0000, "R1", 0, 0, 0, 0);

        // Program the three typical windows
        wr(0, 0, 64'h0080_0003, "R2"); wr(0, 1, 64'h0070_0000, "R2"); wr(0, 2, 64'h2_0000_0000, "R2");
        wr(1, 0, 64'h8000_0001, "R2"); wr(1, 1, 64'h3FF0_0000, "R2"); wr(1, 2, 64'h0, "R2");
        wr(2, 0, 64'hC000_0003, "R2"); wr(2, 1, 64'h3FF0_0000, "R2"); wr(2, 2, 64'h1_0004_0000, "R2");
        @(negedge clk);

        rq_chk(0, 64'h8123_4567, "R3", 1, 1, 0, 64'h0123_4567);
        rq_chk(0, 64'h0080_2000, "R4", 1, 0, 1, 64'h2_0000_0008);
        rq_chk(0, 64'hC000_E010, "R4", 1, 2, 1, 64'h1_0004_0038);
        rq_chk(0, 64'h4000_0000, "R9", 0, 0, 0, 0);
        rq_chk(0, 64'h00FF_FFFF, "R2", 1, 0, 1, 64'h2_0000_0000 + 64'h3FF * 8);
        rq_chk(0, 64'h0100_0000, "R2", 0, 0, 0, 0);
        rq_chk(1, 64'h0000_0002_8000_0000, "R2", 0, 0, 0, 0);
        rq_chk(1, 64'h0000_0000_8000_0040, "R2", 1, 1, 0, 64'h40);
        @(negedge clk);
        note(!rsp_hit && !rsp_miss, "R9", $sformatf("idle outcome act=%b%b exp=00", rsp_hit, rsp_miss));

        // Overlapping window 3 over 2 GB..4 GB, direct
        wr(3, 0, 64'h8000_0001, "R5"); wr(3, 1, 64'h7FF0_0000, "R5"); wr(3, 2, 64'h4_0000_0000, "R5");
        @(negedge clk);
        rq_chk(0, 64'h8000_1000, "R5", 1, 1, 0, 64'h1000);
        rq_chk(0, 64'hC000_2000, "R5", 1, 2, 1, 64'h1_0004_0008);
        wr(1, 0, 64'h0, "R2");
        @(negedge clk);
        rq_chk(0, 64'h8000_1000, "R2", 1, 3, 0, 64'h4_0000_1000);

        // Bypass off, then on
        rq_chk(1, 64'h0000_01F8_1234_5678, "R7", 0, 0, 0, 0);
        wr(0, 3, 64'h1, "R7");
        @(negedge clk);
        rq_chk(1, 64'h0000_01F8_1234_5678, "R6", 1, 0, 2, 64'h0_1234_5678);
        rq_chk(1, 64'h0000_0107_FFFF_FFFF, "R6", 1, 0, 2, 64'h7_FFFF_FFFF);
        rq_chk(1, 64'h0000_0200_0000_0000, "R6", 0, 0, 0, 0);
        rq_chk(0, 64'h0000_0100_8000_1000, "R7", 1, 3, 0, 64'h4_0000_1000);
        rq_chk(0, 64'h0000_0100_4000_0000, "R7", 0, 0, 0, 0);

        // Illegal translated base is rejected and flagged
        wr(0, 2, 64'h3_0000_0004, "R8");
        note(cfg_err == 1'b1, "R8", $sformatf("cfg_err act=%b exp=1", cfg_err));
        @(negedge clk);
        note(cfg_err == 1'b0, "R8", $sformatf("cfg_err pulse act=%b exp=0", cfg_err));
        rq_chk(0, 64'h0080_4000, "R8", 1, 0, 1, 64'h2_0000_0010);
        wr(0, 2, 64'h3_0000_0400, "R8");
        @(negedge clk);
        rq_chk(0, 64'h0080_4000, "R8", 1, 0, 1, 64'h3_0000_0410);

        // Random traffic over programmed and empty ranges
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a;
            bit d;
            a = {$urandom, $urandom};
            d = $urandom_range(0, 1);
            case ($urandom_range(0, 3))
                0: a[63:32] = 32'h0;
                1: a[63:40] = 24'h000001;
                2: a = {32'h0, 2'b10, a[29:0]};
                default: ;
            endcase
            cur_tag = "R2";
            req_valid = $urandom_range(0, 3) != 0; req_dac = req_valid && d; req_addr = a;
            @(negedge clk);
        end
        req_valid = 0; req_dac = 0; req_addr = '0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule